// File: doc/BRIEF.md
# Variable-Length Register-Mapped SPI Master

This block is a single-frame SPI master that a processor drives through a small bank of eight 16-bit registers. Software loads a 32-bit transmit word through two halfword registers and left-justifies the data, so the first bit to go out is bit 31. It then writes a control word that sets the frame length (1 to 32 bits), a device address and the kind of transfer. Writing that word starts the frame. In a write-only transfer the block only shifts data out. In a write-and-read transfer it also samples the input line and stores the received bits right-justified in a 32-bit receive word.

While a frame runs, the addressed active-low chip select stays asserted. The serial clock idles low and runs at the system clock divided by a power of two that software selects. Two end flags report completion and can raise an interrupt unless masked. Reading the status register clears both flags. A control write that arrives while a frame is in progress is dropped.

Top module: `spim_top`

## Requirements
- R1: The register bank is addressed by `bus_addr` as a halfword index. 0 is setup A: bit 0 enables the clock, bit 4 masks the write-end interrupt, bit 5 masks the read-end interrupt. 1 is setup B: bits [1:0] give the divide exponent. 2 is control, which reads back bits [9:0] as last accepted. 3 is status. 4 and 5 are the transmit low and high halves. 6 and 7 are the receive low and high halves. Undefined bits read 0, and writes to 3, 6 and 7 have no effect.
- R2: A control write launches a frame only when setup A bit 0 is set, no frame is running, and control bit 0 (write-and-read) or bit 1 (write-only) is set. Control bits [6:2] hold the frame length minus one. Control bits [9:7] hold the device address.
- R3: The serial output line sends bits 31 down to 32-N of {tx_high, tx_low}, most significant first. When no frame runs, the output line is low.
- R4: A write-and-read frame first clears the receive word, then shifts each sampled bit in at bit 0, so N bits end up in bits N-1..0 with the first bit at N-1. A write-only frame leaves the receive word unchanged.
- R5: The serial clock idles low. With divide exponent d, each half-period lasts 2^d system clocks. The output line changes only on falling edges, and the input line is sampled on rising edges. A frame of N bits keeps the block busy for (2N+1)·2^d clocks, counted from the control write.
- R6: The block has one active-low select per address 0..4. The addressed line is low for the whole frame and goes high one half-period after the last falling edge. Addresses 5..7 run the frame with no line asserted. At most one line is low at any time.
- R7: Status bit 1 (write end) sets when any frame completes. Status bit 0 (read end) sets when a write-and-read frame completes. A status read clears both bits, except that a bit which sets on the same clock stays set.
- R8: A control write that arrives while a frame is running has no effect on the control register, the running frame, or the flags.
- R9: While setup A bit 0 is clear, a control write starts no frame, all selects stay high, and the serial clock stays low.
- R10: `irq` is high while (write end and not setup A bit 4) or (read end and not setup A bit 5).
- R11: After reset, every register reads 0, all selects are high, and the serial clock, the output line and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Halfword register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low device selects |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The bench builds the block with its defaults: five select lines and a 2-bit divide exponent. This covers every half-period from 1 to 8 clocks and lets the 3-bit address field reach values (5 to 7) that have no select line. Frames of 1, 3, 5, 8, 12, 16, 20 and 32 bits are run against a per-clock behavioural model. Together they cover the single-bit minimum, the full-word maximum, and receive data that spans both receive halves.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int HALF_W     = 16;
    localparam int WORD_W     = 2 * HALF_W;
    localparam int LEN_W      = $clog2(WORD_W);
    localparam int DEV_W      = 3;

    typedef enum logic [2:0] {
        A_SETUP1 = 3'd0,
        A_SETUP2 = 3'd1,
        A_CTRL   = 3'd2,
        A_STATUS = 3'd3,
        A_TXLO   = 3'd4,
        A_TXHI   = 3'd5,
        A_RXLO   = 3'd6,
        A_RXHI   = 3'd7
    } reg_idx_e;

    localparam int SU1_EN_BIT     = 0;
    localparam int SU1_WMASK_BIT  = 4;
    localparam int SU1_RWMASK_BIT = 5;

    localparam int CTL_RW_BIT  = 0;
    localparam int CTL_WO_BIT  = 1;
    localparam int CTL_LEN_LSB = 2;
    localparam int CTL_DEV_LSB = CTL_LEN_LSB + LEN_W;
    localparam int CTL_USED_W  = CTL_DEV_LSB + DEV_W;

    localparam int ST_RDEND_BIT = 0;
    localparam int ST_WREND_BIT = 1;

    typedef struct packed {
        logic             with_read;
        logic [LEN_W-1:0] last_idx;
        logic [DEV_W-1:0] dev;
    } frame_cmd_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH,
        PH_TAIL
    } phase_e;

    function automatic frame_cmd_t decode_ctrl(input logic [HALF_W-1:0] w);
        frame_cmd_t c;
        c.with_read = w[CTL_RW_BIT];
        c.last_idx  = w[CTL_LEN_LSB +: LEN_W];
        c.dev       = w[CTL_DEV_LSB +: DEV_W];
        return c;
    endfunction

endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb limit = CNT_W'((1 << sel_q) - 1);
    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else begin
            if (start) sel_q <= sel;
            if (!run || tick) cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= limit)); // R5

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int NUM_CS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  frame_cmd_t        cmd,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              done_read,
    output logic              sclk,
    output logic              mosi,
    output logic [NUM_CS-1:0] cs_n,
    output logic [WORD_W-1:0] rx_word
);
    phase_e            ph_q;
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] rx_q;
    logic [LEN_W-1:0]  left_q;
    logic [DEV_W-1:0]  dev_q;
    logic              rd_q;
    logic              sclk_q;
    logic              cs_act_q;
    logic [NUM_CS-1:0] hit;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
        assign hit[i] = (dev_q == DEV_W'(i));
    end

    assign busy      = (ph_q != PH_IDLE);
    assign done      = (ph_q == PH_TAIL) && tick;
    assign done_read = rd_q;
    assign sclk      = sclk_q;
    assign mosi      = busy ? sh_q[WORD_W-1] : 1'b0;
    assign cs_n      = ~(hit & {NUM_CS{cs_act_q}});
    assign rx_word   = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            sh_q     <= '0;
            rx_q     <= '0;
            left_q   <= '0;
            dev_q    <= '0;
            rd_q     <= 1'b0;
            sclk_q   <= 1'b0;
            cs_act_q <= 1'b0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (start) begin
                    sh_q     <= tx_word;
                    left_q   <= cmd.last_idx;
                    dev_q    <= cmd.dev;
                    rd_q     <= cmd.with_read;
                    cs_act_q <= 1'b1;
                    if (cmd.with_read) rx_q <= '0;
                    ph_q     <= PH_LOW;
                end
                PH_LOW: if (tick) begin
                    sclk_q <= 1'b1;
                    if (rd_q) rx_q <= {rx_q[WORD_W-2:0], miso};
                    ph_q   <= PH_HIGH;
                end
                PH_HIGH: if (tick) begin
                    sclk_q <= 1'b0;
                    if (left_q == '0) begin
                        ph_q <= PH_TAIL;
                    end else begin
                        sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
                        left_q <= left_q - 1'b1;
                        ph_q   <= PH_LOW;
                    end
                end
                PH_TAIL: if (tick) begin
                    cs_act_q <= 1'b0;
                    ph_q     <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk); // R5
    AST_MOSI_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (busy && $rose(sclk)) |-> $stable(mosi)); // R5
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n)); // R6
    AST_CS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (&cs_n)); // R6

endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              done_read,
    input  logic [WORD_W-1:0] rx_word,
    output logic              start,
    output frame_cmd_t        cmd,
    output logic [WORD_W-1:0] tx_word,
    output logic [SEL_W-1:0]  div_sel,
    output logic              enable,
    output logic              irq
);
    reg_idx_e              idx;
    logic                  wr_en, rd_en, ctrl_wr, status_rd, go_bits;
    logic                  en_q, wmask_q, rwmask_q;
    logic [SEL_W-1:0]      div_q;
    logic [CTL_USED_W-1:0] ctrl_q;
    logic [HALF_W-1:0]     txlo_q, txhi_q;
    logic                  rdend_q, wrend_q;

    assign idx       = reg_idx_e'(bus_addr);
    assign wr_en     = bus_sel & bus_wr;
    assign rd_en     = bus_sel & ~bus_wr;
    assign ctrl_wr   = wr_en && (idx == A_CTRL);
    assign status_rd = rd_en && (idx == A_STATUS);
    assign go_bits   = bus_wdata[CTL_RW_BIT] | bus_wdata[CTL_WO_BIT];
    assign start     = ctrl_wr & ~busy & go_bits & en_q;
    assign cmd       = decode_ctrl(bus_wdata);
    assign tx_word   = {txhi_q, txlo_q};
    assign div_sel   = div_q;
    assign enable    = en_q;
    assign irq       = (wrend_q & ~wmask_q) | (rdend_q & ~rwmask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            wmask_q  <= 1'b0;
            rwmask_q <= 1'b0;
            div_q    <= '0;
            ctrl_q   <= '0;
            txlo_q   <= '0;
            txhi_q   <= '0;
            rdend_q  <= 1'b0;
            wrend_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (idx)
                    A_SETUP1: begin
                        en_q     <= bus_wdata[SU1_EN_BIT];
                        wmask_q  <= bus_wdata[SU1_WMASK_BIT];
                        rwmask_q <= bus_wdata[SU1_RWMASK_BIT];
                    end
                    A_SETUP2: div_q  <= bus_wdata[SEL_W-1:0];
                    A_CTRL:   if (!busy) ctrl_q <= bus_wdata[CTL_USED_W-1:0];
                    A_TXLO:   txlo_q <= bus_wdata;
                    A_TXHI:   txhi_q <= bus_wdata;
                    default: ;
                endcase
            end
            if (done)           wrend_q <= 1'b1;
            else if (status_rd) wrend_q <= 1'b0;
            if (done && done_read) rdend_q <= 1'b1;
            else if (status_rd)    rdend_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            A_SETUP1: begin
                bus_rdata[SU1_EN_BIT]     = en_q;
                bus_rdata[SU1_WMASK_BIT]  = wmask_q;
                bus_rdata[SU1_RWMASK_BIT] = rwmask_q;
            end
            A_SETUP2: bus_rdata[SEL_W-1:0]      = div_q;
            A_CTRL:   bus_rdata[CTL_USED_W-1:0] = ctrl_q;
            A_STATUS: begin
                bus_rdata[ST_RDEND_BIT] = rdend_q;
                bus_rdata[ST_WREND_BIT] = wrend_q;
            end
            A_TXLO:   bus_rdata = txlo_q;
            A_TXHI:   bus_rdata = txhi_q;
            A_RXLO:   bus_rdata = rx_word[HALF_W-1:0];
            A_RXHI:   bus_rdata = rx_word[WORD_W-1:HALF_W];
            default:  bus_rdata = '0;
        endcase
    end

    AST_CTRL_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && busy) |=> $stable(ctrl_q)); // R8
    AST_WREND_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> wrend_q); // R7
    AST_RDEND_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rdend_q) |-> $past(done && done_read)); // R7

endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int NUM_CS    = 5,
    parameter int DIV_SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              irq
);
    logic                 start, busy, done, done_read, tick, enable;
    frame_cmd_t           cmd;
    logic [WORD_W-1:0]    tx_word, rx_word;
    logic [DIV_SEL_W-1:0] div_sel;

    spim_regs #(.SEL_W(DIV_SEL_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done      (done),
        .done_read (done_read),
        .rx_word   (rx_word),
        .start     (start),
        .cmd       (cmd),
        .tx_word   (tx_word),
        .div_sel   (div_sel),
        .enable    (enable),
        .irq       (irq)
    );

    spim_clkdiv #(.SEL_W(DIV_SEL_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .run   (busy),
        .sel   (div_sel),
        .tick  (tick)
    );

    spim_engine #(.NUM_CS(NUM_CS)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd       (cmd),
        .tx_word   (tx_word),
        .tick      (tick),
        .miso      (miso),
        .busy      (busy),
        .done      (done),
        .done_read (done_read),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_n      (cs_n),
        .rx_word   (rx_word)
    );

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!busy && !enable) |=> !busy); // R9

endmodule

// File: tb/tb_spim_top.sv
module tb_spim_top;
    localparam int NCS = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk, mosi, irq;
    logic        miso = 1'b0;
    logic [NCS-1:0] cs_n;

    int n_chk = 0, n_fail = 0;
    bit miso_const = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    spim_top dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic        m_en, m_mw, m_mrw, m_busy, m_rd, m_re, m_we;
    logic [1:0]  m_div;
    logic [9:0]  m_ctrl;
    logic [15:0] m_txlo, m_txhi;
    logic [31:0] m_rx, m_ftx;
    int          m_t, m_n, m_h, m_dev;

    always @(posedge clk) begin
        int  nt;
        bit  fin, srd;
        if (rst) begin
            m_en <= 0; m_mw <= 0; m_mrw <= 0; m_busy <= 0; m_rd <= 0;
            m_re <= 0; m_we <= 0; m_div <= 0; m_ctrl <= 0; m_txlo <= 0;
            m_txhi <= 0; m_rx <= 0; m_ftx <= 0; m_t <= 0; m_n <= 1; m_h <= 1; m_dev <= 0;
        end else begin
            nt  = m_t + 1;
            fin = m_busy && (nt == (2*m_n + 1) * m_h);
            srd = bus_sel && !bus_wr && (bus_addr == 3'd3);
            if (m_busy) begin
                m_t <= nt;
                if (m_rd && (nt % (2*m_h) == m_h) && (nt < 2*m_n*m_h))
                    m_rx <= {m_rx[30:0], miso};
                if (fin) m_busy <= 0;
            end
            if (fin) m_we <= 1; else if (srd) m_we <= 0;
            if (fin && m_rd) m_re <= 1; else if (srd) m_re <= 0;
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    3'd0: begin m_en <= bus_wdata[0]; m_mw <= bus_wdata[4]; m_mrw <= bus_wdata[5]; end
                    3'd1: m_div <= bus_wdata[1:0];
                    3'd2: if (!m_busy) begin
                        m_ctrl <= bus_wdata[9:0];
                        if (m_en && (bus_wdata[0] || bus_wdata[1])) begin
                            m_busy <= 1; m_t <= 0;
                            m_n <= int'(bus_wdata[6:2]) + 1;
                            m_h <= 1 << m_div;
                            m_rd <= bus_wdata[0];
                            m_dev <= int'(bus_wdata[9:7]);
                            m_ftx <= {m_txhi, m_txlo};
                            if (bus_wdata[0]) m_rx <= 0;
                        end
                    end
                    3'd4: m_txlo <= bus_wdata;
                    3'd5: m_txhi <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    logic e_sclk, e_mosi, e_irq;
    logic [NCS-1:0] e_cs;
    logic [15:0] e_rdata;
    always_comb begin
        int ph, ix;
        e_sclk = 0; e_mosi = 0; e_cs = '1;
        if (m_busy) begin
            ph = m_t / m_h;
            if (ph < 2*m_n) e_sclk = (ph % 2) == 1;
            ix = ph / 2;
            if (ix > m_n - 1) ix = m_n - 1;
            e_mosi = m_ftx[31 - ix];
            if (m_dev < NCS) e_cs[m_dev] = 1'b0;
        end
        e_irq = (m_we && !m_mw) || (m_re && !m_mrw);
        case (bus_addr)
            3'd0: e_rdata = {10'b0, m_mrw, m_mw, 3'b0, m_en};
            3'd1: e_rdata = {14'b0, m_div};
            3'd2: e_rdata = {6'b0, m_ctrl};
            3'd3: e_rdata = {14'b0, m_we, m_re};
            3'd4: e_rdata = m_txlo;
            3'd5: e_rdata = m_txhi;
            3'd6: e_rdata = m_rx[15:0];
            default: e_rdata = m_rx[31:16];
        endcase
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(sclk === e_sclk, "R5 sclk", {31'b0, sclk}, {31'b0, e_sclk});
            chk(mosi === e_mosi, "R3 mosi", {31'b0, mosi}, {31'b0, e_mosi});
            chk(cs_n === e_cs, "R6 cs_n", 32'(cs_n), 32'(e_cs));
            chk(irq === e_irq, "R10 irq", {31'b0, irq}, {31'b0, e_irq});
            if (bus_sel && !bus_wr)
                chk(bus_rdata === e_rdata, "R1 rdata", 32'(bus_rdata), 32'(e_rdata));
        end
    end

    always begin
        @(posedge clk); #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso = miso_const ? 1'b1 : lfsr[0];
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #2;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(posedge clk); #2;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk); d = bus_rdata;
        @(posedge clk); #2;
        bus_sel = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
        logic [15:0] d;
        rd(a, d);
        chk(d === exp, tag, 32'(d), 32'(exp));
    endtask

    task automatic wait_idle();
        do begin @(posedge clk); #1; end while (m_busy);
    endtask

    function automatic logic [15:0] ctl(input bit r, input int n, input int dev);
        return 16'((r ? 1 : 2) | ((n - 1) << 2) | (dev << 7));
    endfunction

    task automatic frame(input logic [15:0] c, input int exp_cyc, input string tag);
        int cnt = 0;
        wr(3'd2, c);
        forever begin
            @(negedge clk);
            if (&cs_n) break;
            cnt++;
        end
        chk(cnt == exp_cyc, tag, 32'(cnt), 32'(exp_cyc));
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        repeat (4) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        chk(cs_n === '1, "R11 cs idle", 32'(cs_n), 32'h1F);
        chk({sclk, mosi, irq} === 3'b0, "R11 outputs low", {29'b0, sclk, mosi, irq}, 0);
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 16'h0000, "R11 reg reset");

        // R9: disabled clock, no frame
        wr(3'd0, 16'h0030);
        wr(3'd2, ctl(0, 8, 0));
        cnt = 0;
        repeat (20) begin @(negedge clk); if (!(&cs_n) || sclk) cnt++; end
        chk(cnt == 0, "R9 no activity", 32'(cnt), 0);
        rd_chk(3'd3, 16'h0000, "R9 status idle");

        // R1 map readback, R3 write-only frame
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'h0001);
        wr(3'd5, 16'hA5C3);
        wr(3'd4, 16'h1234);
        wr(3'd3, 16'h0003);
        wr(3'd6, 16'hFFFF);
        rd_chk(3'd0, 16'h0001, "R1 setupA");
        rd_chk(3'd1, 16'h0001, "R1 setupB");
        rd_chk(3'd5, 16'hA5C3, "R1 tx high");
        rd_chk(3'd4, 16'h1234, "R1 tx low");
        rd_chk(3'd6, 16'h0000, "R1 rx not writable");
        frame(ctl(0, 8, 0), 34, "R5 frame length d1 N8");
        @(negedge clk);
        chk(irq === 1'b1, "R10 irq on write end", {31'b0, irq}, 1);
        rd_chk(3'd3, 16'h0002, "R7 write end only");
        rd_chk(3'd3, 16'h0000, "R7 cleared by read");
        @(negedge clk);
        chk(irq === 1'b0, "R10 irq cleared", {31'b0, irq}, 0);

        // R4 write-and-read, right-aligned
        miso_const = 1;
        wr(3'd1, 16'h0002);
        frame(ctl(1, 12, 3), 100, "R2 select 3 d2 N12");
        rd_chk(3'd6, 16'h0FFF, "R4 rx low N12");
        rd_chk(3'd7, 16'h0000, "R4 rx high N12");
        rd_chk(3'd3, 16'h0003, "R7 both ends");
        frame(ctl(0, 5, 2), 44, "R5 write-only d2 N5");
        rd_chk(3'd6, 16'h0FFF, "R4 write-only keeps rx");

        wr(3'd1, 16'h0000);
        frame(ctl(1, 20, 1), 41, "R5 d0 N20");
        rd_chk(3'd6, 16'hFFFF, "R4 rx low N20");
        rd_chk(3'd7, 16'h000F, "R4 rx high N20");

        wr(3'd1, 16'h0003);
        frame(ctl(1, 1, 4), 24, "R5 d3 N1");
        rd_chk(3'd6, 16'h0001, "R4 rx N1");
        rd_chk(3'd7, 16'h0000, "R4 rx high N1");

        // full word with varying input
        miso_const = 0;
        wr(3'd1, 16'h0001);
        wr(3'd5, 16'h8001);
        wr(3'd4, 16'h7FFE);
        frame(ctl(1, 32, 0), 130, "R3 d1 N32");
        rd_chk(3'd3, 16'h0003, "R7 after full word");

        // R8: control write while busy
        wr(3'd1, 16'h0000);
        wr(3'd2, ctl(0, 16, 1));
        wr(3'd2, ctl(1, 4, 2));
        rd_chk(3'd2, ctl(0, 16, 1), "R8 ctrl unchanged");
        wait_idle();
        rd_chk(3'd3, 16'h0002, "R8 no read end");

        // R6: address without a select line
        frame(ctl(0, 4, 6), 0, "R6 address 6 no select");
        rd_chk(3'd3, 16'h0002, "R6 frame still ran");

        // R10 masks
        wr(3'd0, 16'h0031);
        frame(ctl(1, 3, 0), 7, "R2 d0 N3");
        @(negedge clk);
        chk(irq === 1'b0, "R10 both masked", {31'b0, irq}, 0);
        wr(3'd0, 16'h0011);
        @(negedge clk);
        chk(irq === 1'b1, "R10 read end unmasked", {31'b0, irq}, 1);
        wr(3'd0, 16'h0021);
        @(negedge clk);
        chk(irq === 1'b1, "R10 write end unmasked", {31'b0, irq}, 1);
        rd_chk(3'd3, 16'h0003, "R7 flags before clear");
        @(negedge clk);
        chk(irq === 1'b0, "R10 irq after clear", {31'b0, irq}, 0);

        repeat (4) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule